// File: doc/BRIEF.md
# Register-Mapped Byte-Serial SPI Master

This block is a half-duplex SPI master that sits on a simple 32-bit register bus. Software loads a byte into the data register and sets a transmit-start bit to send it. To fetch a byte, software sets a separate receive-start bit, waits for the engine to go idle, and then reads the captured byte back from the same data register. Each command moves exactly eight bits. While a command runs, a busy flag in the status register stays set.

The serial clock comes from the system clock through a power-of-two prescaler. The configuration register sets the idle polarity of the clock, the bit order, and which clock edge launches and which edge samples data. The block drives a single slave select straight from a control bit. The serial data output has an output-enable, so the pad can float whenever the block is not transmitting.

Top module: `spim_top`

## Requirements
- R1: After reset, the configuration register reads 0x153, the control register reads 0x9, and status and data read 0. The pins show `spi_ss_n`=1, `spi_sclk`=1 and `spi_mosi_oe`=0.
- R2: Register offsets are status 0x00, configuration 0x10, control 0x14 and data 0x20. Read data appears on `bus_rdata` one cycle after the read request, and any other offset reads 0.
- R3: For configuration bits [2:0] = c with c in 0..6, every half period of `spi_sclk` lasts 2^c system clock cycles, so the divide ratio is 2^(c+1).
- R4: With configuration bits [2:0] = 7, `spi_sclk` does not toggle and a started command stays busy. Writing a code from 0 to 6 resumes the command, and it completes normally.
- R5: Writing control bit 2 sends the low byte of the data register on `spi_mosi`. It goes MSB first when configuration bit 8 is 1 and LSB first when it is 0. The first bit is on the line before the first edge. The line changes only on launch edges (falling when configuration bit 4 is 1, rising when it is 0) and stays stable at every other edge.
- R6: Writing control bit 1 receives a byte from `spi_miso`. It is sampled on falling edges when configuration bit 5 is 1 and on rising edges when it is 0, with the bit order of configuration bit 8. The byte then reads from the data register zero-extended to 32 bits.
- R7: Configuration bit 6 is the idle level of `spi_sclk`. Every command makes exactly 16 clock edges and leaves the clock at that idle level.
- R8: `spi_ss_n` follows control bit 0 one cycle after the write: 0 selects the slave and 1 deselects it.
- R9: While no transmit runs, `spi_mosi` is 0 and `spi_mosi_oe` equals the inverse of control bit 3. During a transmit, `spi_mosi_oe` is 1.
- R10: Control bits 2 and 1 always read back as 0. A start written while busy is ignored. The transmitted byte is captured when the command starts, so later data writes do not change it.
- R11: Status bit 0 is 1 from the cycle after a start is accepted until the command's last clock edge, and 0 otherwise.
- R12: A data register write keeps only bits [7:0], and reads return them zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Output enable for the serial data pad |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Slave select, active low |

## Verification
Corrupted internal state shows up at the pins within one byte time. A wrong edge count gives more or fewer than 16 clock transitions, or leaves the clock away from its idle level. A wrong bit index puts a reordered or shifted byte on the data line at the sampling edges. A bad prescaler limit changes the spacing between transitions from the first half period onward. On the receive side, a misplaced shift or a wrong edge choice returns a different byte from the data register as soon as busy drops. A busy flag that clears early or late shows up in the very next status read.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int PRESC_W = 3;

  localparam int OFS_STAT = 'h00;
  localparam int OFS_CFG  = 'h10;
  localparam int OFS_CTL  = 'h14;
  localparam int OFS_DATA = 'h20;

  localparam int CFG_MSB = 8;
  localparam int CFG_POL = 6;
  localparam int CFG_RXF = 5;
  localparam int CFG_TXF = 4;

  localparam int CTL_HIZ  = 3;
  localparam int CTL_GOTX = 2;
  localparam int CTL_GORX = 1;
  localparam int CTL_EN   = 0;

  typedef struct packed {
    logic               msb_first;
    logic               pol;
    logic               rx_fall;
    logic               tx_fall;
    logic [PRESC_W-1:0] div;
  } spim_cfg_t;

  localparam spim_cfg_t CFG_RESET = '{msb_first: 1'b1, pol: 1'b1, rx_fall: 1'b0,
                                      tx_fall: 1'b1, div: PRESC_W'(3)};
endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          busy_i,
  input  logic          rx_load_i,
  input  logic [BW-1:0] rx_byte_i,
  output spim_cfg_t     cfg_o,
  output logic          ss_en_o,
  output logic          hiz_o,
  output logic [BW-1:0] tx_byte_o,
  output logic          go_tx_o,
  output logic          go_rx_o
);
  logic wr_cfg, wr_ctl, wr_data, rd_req;
  logic [BW-1:0] data_q;
  logic [DW-1:0] rd_mux;

  assign wr_cfg  = bus_req & bus_we & (bus_addr == AW'(OFS_CFG));
  assign wr_ctl  = bus_req & bus_we & (bus_addr == AW'(OFS_CTL));
  assign wr_data = bus_req & bus_we & (bus_addr == AW'(OFS_DATA));
  assign rd_req  = bus_req & ~bus_we;

  // start requests; transmit wins when both bits are written together
  assign go_tx_o = wr_ctl & bus_wdata[CTL_GOTX];
  assign go_rx_o = wr_ctl & bus_wdata[CTL_GORX] & ~bus_wdata[CTL_GOTX];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o   <= CFG_RESET;
      ss_en_o <= 1'b1;
      hiz_o   <= 1'b1;
    end else begin
      if (wr_cfg) begin
        cfg_o.msb_first <= bus_wdata[CFG_MSB];
        cfg_o.pol       <= bus_wdata[CFG_POL];
        cfg_o.rx_fall   <= bus_wdata[CFG_RXF];
        cfg_o.tx_fall   <= bus_wdata[CFG_TXF];
        cfg_o.div       <= bus_wdata[PRESC_W-1:0];
      end
      if (wr_ctl) begin
        ss_en_o <= bus_wdata[CTL_EN];
        hiz_o   <= bus_wdata[CTL_HIZ];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            data_q <= '0;
    else if (rx_load_i) data_q <= rx_byte_i;
    else if (wr_data)   data_q <= bus_wdata[BW-1:0];
  end
  assign tx_byte_o = data_q;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFS_STAT)) begin
      rd_mux[0] = busy_i;
    end else if (bus_addr == AW'(OFS_CFG)) begin
      rd_mux[CFG_MSB]       = cfg_o.msb_first;
      rd_mux[CFG_POL]       = cfg_o.pol;
      rd_mux[CFG_RXF]       = cfg_o.rx_fall;
      rd_mux[CFG_TXF]       = cfg_o.tx_fall;
      rd_mux[PRESC_W-1:0]   = cfg_o.div;
    end else if (bus_addr == AW'(OFS_CTL)) begin
      rd_mux[CTL_HIZ] = hiz_o;
      rd_mux[CTL_EN]  = ss_en_o;
    end else if (bus_addr == AW'(OFS_DATA)) begin
      rd_mux[BW-1:0] = data_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_mux;
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[DW-1:CFG_MSB+1], bus_wdata[CFG_MSB-1:CFG_POL+1]};

  // a captured receive byte only arrives while a command is in flight
  assert_load_in_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    rx_load_i |-> busy_i);
endmodule

// File: rtl/spim_prescaler.sv
module spim_prescaler #(
  parameter int PW = spim_pkg::PRESC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic [PW-1:0] code_i,
  output logic          tick_o
);
  localparam int CNT_W = (1 << PW) - 2;

  logic [CNT_W-1:0] cnt_q, lim;
  logic stop;

  // half-period limit is 2^code - 1: a run of code ones
  always_comb begin
    lim = '0;
    for (int k = 0; k < CNT_W; k++) begin
      if (k < int'(code_i)) lim[k] = 1'b1;
    end
  end

  assign stop   = &code_i;
  assign tick_o = run_i & ~stop & (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt_q <= '0;
    else if (!stop)              cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    (run_i && $past(run_i) && !stop && $stable(code_i) && !$past(tick_o)) |-> cnt_q <= lim);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int BW = spim_pkg::BYTE_W,
  parameter logic SCLK_RST = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_tx_i,
  input  logic          go_rx_i,
  input  logic [BW-1:0] tx_byte_i,
  input  logic          msb_first_i,
  input  logic          pol_i,
  input  logic          rx_fall_i,
  input  logic          tx_fall_i,
  input  logic          hiz_i,
  input  logic          tick_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          mosi_oe_o,
  output logic          rx_load_o,
  output logic [BW-1:0] rx_byte_o
);
  localparam int EDGES  = 2 * BW;
  localparam int ECNT_W = $clog2(EDGES + 1);
  localparam int IDX_W  = $clog2(BW);

  logic              busy_q, is_tx_q, msb_q, pol_q, rxf_q, lead_q;
  logic              sclk_q, mosi_q, oe_q;
  logic [ECNT_W-1:0] ecnt_q, ecnt_n;
  logic [BW-1:0]     tx_q, rx_q, rx_shift, rx_next;
  logic              step, fall_n, last, sample_now;

  // bit index on the line after e edges; lead = launch on the leading edge
  function automatic logic [IDX_W-1:0] bit_idx(input logic [ECNT_W-1:0] e, input logic lead);
    logic [ECNT_W-1:0] h;
    if (lead) h = (e == '0) ? '0 : ((e - ECNT_W'(1)) >> 1);
    else      h = e >> 1;
    if (h > ECNT_W'(BW - 1)) h = ECNT_W'(BW - 1);
    return h[IDX_W-1:0];
  endfunction

  function automatic logic pick(input logic [BW-1:0] b, input logic [IDX_W-1:0] i,
                                input logic msb);
    return msb ? b[IDX_W'(BW - 1) - i] : b[i];
  endfunction

  assign step       = busy_q & tick_i;
  assign fall_n     = sclk_q;
  assign ecnt_n     = ecnt_q + ECNT_W'(1);
  assign last       = (ecnt_n == ECNT_W'(EDGES));
  assign rx_shift   = msb_q ? {rx_q[BW-2:0], miso_i} : {miso_i, rx_q[BW-1:1]};
  assign sample_now = step & ~is_tx_q & (fall_n == rxf_q);
  assign rx_next    = sample_now ? rx_shift : rx_q;
  assign rx_load_o  = step & ~is_tx_q & last;
  assign rx_byte_o  = rx_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      is_tx_q <= 1'b0;
      ecnt_q  <= '0;
      sclk_q  <= SCLK_RST;
      mosi_q  <= 1'b0;
      oe_q    <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      msb_q   <= 1'b1;
      pol_q   <= SCLK_RST;
      rxf_q   <= 1'b0;
      lead_q  <= 1'b0;
    end else if (!busy_q) begin
      sclk_q <= pol_i;
      mosi_q <= 1'b0;
      oe_q   <= ~hiz_i;
      if (go_tx_i || go_rx_i) begin
        busy_q  <= 1'b1;
        is_tx_q <= go_tx_i;
        ecnt_q  <= '0;
        msb_q   <= msb_first_i;
        pol_q   <= pol_i;
        rxf_q   <= rx_fall_i;
        lead_q  <= (pol_i == tx_fall_i);
        tx_q    <= tx_byte_i;
        rx_q    <= '0;
        if (go_tx_i) begin
          mosi_q <= pick(tx_byte_i, '0, msb_first_i);
          oe_q   <= 1'b1;
        end
      end
    end else begin
      oe_q <= is_tx_q | ~hiz_i;
      if (step) begin
        sclk_q <= ~sclk_q;
        ecnt_q <= ecnt_n;
        rx_q   <= rx_next;
        if (is_tx_q) mosi_q <= pick(tx_q, bit_idx(ecnt_n, lead_q), msb_q);
        if (last)    busy_q <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = mosi_q;
  assign mosi_oe_o = oe_q;

  assert_edge_bound_R7: assert property (@(posedge clk) disable iff (rst)
    ecnt_q <= ECNT_W'(EDGES));
  assert_end_at_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (ecnt_q == ECNT_W'(EDGES)) && (sclk_q == pol_q));
  assert_idle_clock_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(!busy_q)) |-> sclk_q == $past(pol_i));
  assert_start_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(go_tx_i || go_rx_i));
  assert_tx_drives_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && is_tx_q) |-> mosi_oe_o);
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_mosi_oe,
  input  logic              spi_miso,
  output logic              spi_ss_n
);
  spim_cfg_t         cfg;
  logic              ss_en, hiz, go_tx, go_rx, busy, tick, rx_load;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic              ss_q;

  spim_regs #(.AW(ADDR_W), .DW(DATA_W), .BW(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_i(busy), .rx_load_i(rx_load),
    .rx_byte_i(rx_byte), .cfg_o(cfg), .ss_en_o(ss_en), .hiz_o(hiz), .tx_byte_o(tx_byte),
    .go_tx_o(go_tx), .go_rx_o(go_rx));

  spim_prescaler #(.PW(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .run_i(busy), .code_i(cfg.div), .tick_o(tick));

  spim_shifter #(.BW(BYTE_W), .SCLK_RST(CFG_RESET.pol)) u_shift (
    .clk(clk), .rst(rst), .go_tx_i(go_tx), .go_rx_i(go_rx), .tx_byte_i(tx_byte),
    .msb_first_i(cfg.msb_first), .pol_i(cfg.pol), .rx_fall_i(cfg.rx_fall),
    .tx_fall_i(cfg.tx_fall), .hiz_i(hiz), .tick_i(tick), .miso_i(spi_miso),
    .busy_o(busy), .sclk_o(spi_sclk), .mosi_o(spi_mosi), .mosi_oe_o(spi_mosi_oe),
    .rx_load_o(rx_load), .rx_byte_o(rx_byte));

  always_ff @(posedge clk) begin
    if (rst) ss_q <= 1'b1;
    else     ss_q <= ss_en;
  end
  assign spi_ss_n = ss_q;

  assert_ss_follows_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> spi_ss_n == $past(ss_en));
  assert_stall_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (&cfg.div) && (&$past(cfg.div))) |-> $stable(spi_sclk));
endmodule

// File: tb/spim_top_tb.sv
`timescale 1ns/1ps
module spim_top_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sclk, spi_mosi, spi_mosi_oe, spi_ss_n, spi_miso;

  always #2.5 clk = ~clk;

  spim_top u_dut (.clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe),
    .spi_miso(spi_miso), .spi_ss_n(spi_ss_n));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  // pin monitor and slave model
  logic p_sclk = 1'b1, p_mosi = 1'b0;
  logic mon_tx = 1'b1, mon_txf = 1'b0, mon_rxf = 1'b0, rx_msb = 1'b1;
  int mon_edges, mon_last, sp_min, sp_max, glitch, rx_idx;
  logic oe_seen;
  logic [7:0] rec, rx_pat;

  assign spi_miso = (rx_idx < 8) ? (rx_msb ? rx_pat[7 - rx_idx] : rx_pat[rx_idx]) : 1'b0;

  task automatic mon_clear();
    mon_edges = 0; mon_last = 0; sp_min = 1 << 20; sp_max = 0;
    glitch = 0; rx_idx = 0; oe_seen = 1'b0; rec = '0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (spi_sclk !== p_sclk) begin
      if (mon_edges > 0) begin
        if (cyc - mon_last < sp_min) sp_min = cyc - mon_last;
        if (cyc - mon_last > sp_max) sp_max = cyc - mon_last;
      end
      mon_last = cyc;
      if (mon_tx && ((spi_sclk == 1'b0) != mon_txf)) begin
        rec = {rec[6:0], p_mosi};
        if (spi_mosi !== p_mosi) glitch++;
      end
      if (!mon_tx && ((spi_sclk == 1'b0) == mon_rxf)) rx_idx++;
      mon_edges++;
    end else if (mon_tx && spi_mosi !== p_mosi && mon_edges > 0 && mon_edges < 16) begin
      glitch++;
    end
    if (spi_mosi_oe) oe_seen = 1'b1;
    p_sclk = spi_sclk;
    p_mosi = spi_mosi;
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_req = 1'b0; d = bus_rdata;
  endtask

  task automatic poll(output logic ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      rd(8'h00, s);
      if (s[0] == 1'b0) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [31:0] cfgv(input logic msb, input logic pol, input logic rxf,
                                       input logic txf, input logic [2:0] code);
    return (32'(msb) << 8) | (32'(pol) << 6) | (32'(rxf) << 5) | (32'(txf) << 4) | 32'(code);
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7 - i];
    return r;
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic ok;
    mon_clear();
    rx_pat = '0;
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset values
    chk(spi_ss_n == 1'b1, "R1 ss_n", spi_ss_n, 1);
    chk(spi_sclk == 1'b1, "R1 sclk", spi_sclk, 1);
    chk(spi_mosi_oe == 1'b0, "R1 oe", spi_mosi_oe, 0);
    rd(8'h10, d); chk(d == 32'h153, "R1 cfg", d, 32'h153);
    rd(8'h14, d); chk(d == 32'h9, "R1 ctl", d, 32'h9);
    rd(8'h00, d); chk(d == 32'h0, "R1 status", d, 0);
    rd(8'h20, d); chk(d == 32'h0, "R1 data", d, 0);
    // R2 unmapped offset
    rd(8'h04, d); chk(d == 32'h0, "R2 unmapped", d, 0);
    // R12 data write keeps low byte
    wr(8'h20, 32'hABCD1234);
    rd(8'h20, d); chk(d == 32'h34, "R12 data", d, 32'h34);

    // R8 slave select
    wr(8'h14, 32'h8); idle(1);
    chk(spi_ss_n == 1'b0, "R8 select", spi_ss_n, 0);
    wr(8'h14, 32'h9); idle(1);
    chk(spi_ss_n == 1'b1, "R8 deselect", spi_ss_n, 1);

    // R9 output enable while idle
    wr(8'h14, 32'h1); idle(2);
    chk(spi_mosi_oe == 1'b1 && spi_mosi == 1'b0, "R9 driven idle", {spi_mosi_oe, spi_mosi}, 2'b10);
    wr(8'h14, 32'h9); idle(2);
    chk(spi_mosi_oe == 1'b0, "R9 hiz idle", spi_mosi_oe, 0);

    // transmit sweep: R3 R5 R7 R10 R11
    for (int code = 0; code < 3; code++) begin
      for (int m = 0; m < 8; m++) begin
        logic msb, pol, txf;
        logic [7:0] b, exp;
        msb = m[0]; pol = m[1]; txf = m[2];
        b = 8'h5A ^ 8'(m * 37 + code * 11);
        wr(8'h10, cfgv(msb, pol, 1'b0, txf, 3'(code)));
        idle(3);
        wr(8'h20, {24'hFFFFFF, b});
        mon_tx = 1'b1; mon_txf = txf; mon_clear();
        wr(8'h14, 32'hC);
        rd(8'h00, d); chk(d == 32'h1, "R11 busy set", d, 1);
        rd(8'h14, d); chk(d == 32'h8, "R10 start bits clear", d, 32'h8);
        poll(ok); chk(ok, "R11 busy clears", ok, 1);
        idle(2);
        exp = msb ? b : rev8(b);
        chk(rec == exp, "R5 tx bits", rec, exp);
        chk(glitch == 0, "R5 launch edges only", glitch, 0);
        chk(mon_edges == 16, "R7 edge count", mon_edges, 16);
        chk(spi_sclk == pol, "R7 idle level", spi_sclk, pol);
        chk(sp_min == (1 << code) && sp_max == (1 << code), "R3 half period", sp_max, 1 << code);
      end
    end

    // receive sweep: R6 R9
    mon_tx = 1'b0;
    for (int code = 0; code < 3; code++) begin
      for (int m = 0; m < 8; m++) begin
        logic msb, pol, rxf;
        msb = m[0]; pol = m[1]; rxf = m[2];
        wr(8'h10, cfgv(msb, pol, rxf, 1'b0, 3'(code)));
        idle(3);
        rx_pat = 8'h96 ^ 8'(m * 29 + code * 7);
        rx_msb = msb; mon_rxf = rxf; mon_clear();
        wr(8'h14, 32'hA);
        poll(ok); chk(ok, "R11 rx busy clears", ok, 1);
        rd(8'h20, d); chk(d == {24'h0, rx_pat}, "R6 rx byte", d, {24'h0, rx_pat});
        chk(mon_edges == 16, "R7 rx edge count", mon_edges, 16);
        chk(!oe_seen, "R9 hiz during rx", oe_seen, 0);
      end
    end

    // R4 stopped clock
    mon_tx = 1'b1; mon_txf = 1'b1;
    wr(8'h10, cfgv(1'b1, 1'b1, 1'b0, 1'b1, 3'd7)); idle(3);
    wr(8'h20, 32'h3C); mon_clear();
    wr(8'h14, 32'hC);
    idle(60);
    chk(mon_edges == 0, "R4 no edges", mon_edges, 0);
    rd(8'h00, d); chk(d == 32'h1, "R4 still busy", d, 1);
    wr(8'h10, cfgv(1'b1, 1'b1, 1'b0, 1'b1, 3'd0));
    poll(ok); chk(ok, "R4 resumes", ok, 1);
    idle(2);
    chk(mon_edges == 16 && rec == 8'h3C, "R4 completes", rec, 8'h3C);

    // R10 start while busy ignored, byte captured at start
    mon_txf = 1'b0;
    wr(8'h10, cfgv(1'b1, 1'b0, 1'b0, 1'b0, 3'd1)); idle(3);
    wr(8'h20, 32'hA5); mon_clear();
    wr(8'h14, 32'hC);
    wr(8'h20, 32'h5A);
    wr(8'h14, 32'hC);
    poll(ok);
    idle(40);
    chk(mon_edges == 16, "R10 second start ignored", mon_edges, 16);
    chk(rec == 8'hA5, "R10 captured byte", rec, 8'hA5);
    rd(8'h20, d); chk(d == 32'h5A, "R12 data after busy write", d, 32'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule